// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block is the part of a small CPU that carries out the hardware side of taking an interrupt. The decoder tells it when an instruction has finished. At that boundary, if a request is pending and the global enable bit of the status word is set, the sequencer takes over the memory port. It saves the return address and then the status word on a downward-growing stack. It clears the status bits, global enable included, and releases the flag of a dedicated source. It then reads the handler address from a vector slot and loads it into the program counter.

A return-from-interrupt strobe from the decoder runs the opposite sequence. The status word is popped first and the program counter second, so the enable state that held before entry comes back. While either sequence runs, a busy output holds off instruction fetch. The sequencer owns the program counter, stack pointer and status word. Software changes the status word through a write port that only takes effect while the sequencer is idle.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset the PC, SP and status outputs hold their reset parameters (defaults 16'h4400, 16'h2400, 16'h0000), busy is low and no memory access is issued.
- R2: A request starts an entry only in a cycle where insn_done is high, the status bit GIE_BIT (bit 3) is set and the block is idle. At any other time the request changes nothing.
- R3: In the first busy cycle of an entry, the return address is written at SP-2. In the second busy cycle, the status word as it stood before entry is written at SP-4. The SP ends 4 below its starting value.
- R4: After the status push, the status word equals its old value ANDed with the keep mask (default 16'h00F0), so the GIE_BIT is always 0.
- R5: For a dedicated source (irq_grouped=0), flag_clr pulses for exactly one cycle (the vector-read cycle) with flag_clr_idx equal to the accepted index. For a grouped source, flag_clr stays low.
- R6: In the third busy cycle the vector is read at VEC_BASE + 2*index (default base 16'hFF80). The data read becomes the PC when busy falls.
- R7: busy is high for exactly 4 cycles on entry and 3 cycles on return, starting in the cycle after the boundary.
- R8: insn_done together with reti_strobe reads the status word at SP and then the PC at SP+2. It restores both and leaves SP 4 higher. GIE does not gate a return.
- R9: After entry no request nests until software sets GIE again through the status write port. Once GIE is set, a nested entry is accepted.
- R10: sr_wr_en loads sr_wr_data into the status word on the next edge only while idle and not starting a sequence. It is ignored while busy.
- R11: When a return and a request arrive at the same boundary, the return is performed and the request is not.
- R12: insn_done pulses that arrive while busy start nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| insn_done | input | 1 | Current instruction completes this cycle |
| reti_strobe | input | 1 | Completing instruction is a return-from-interrupt |
| irq_req | input | 1 | An arbitrated maskable request is pending |
| irq_idx | input | IDX_W | Vector slot of the pending source or group |
| irq_grouped | input | 1 | Pending slot is shared by a group of sources |
| ret_addr | input | AW | Address of the next instruction, saved on entry |
| sr_wr_en | input | 1 | Software write of the status word |
| sr_wr_data | input | DW | Value for the status write |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Byte address of the access |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid the cycle after a read |
| flag_clr | output | 1 | Clear the flag of a dedicated source |
| flag_clr_idx | output | IDX_W | Slot whose flag is cleared |
| busy | output | 1 | Sequence in progress, fetch held off |
| pc_q | output | AW | Program counter |
| sp_q | output | AW | Stack pointer |
| sr_q | output | DW | Status word |

## Verification
A wrong sequence state shows at the memory port within one cycle of the boundary. The bench catches it as a write of the wrong value, the wrong order of the two pushes, or a stray or missing access. A wrong stack pointer shows in the address of the very next push or pop. It also shows one return later, as a wrong restored PC or status word. A failure to clear GIE only shows when a later request is wrongly nested, so the bench raises a request while GIE should be clear. A lost flag clear or a wrong vector slot shows in the cycle of the vector read.

// File: rtl/irq_seq_pkg.sv
// Shared types for the interrupt entry/return sequencer.
// Assumes a byte-addressed memory with word-sized stack slots.
package irq_seq_pkg;

    localparam int unsigned WORD_BYTES = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH_PC,
        ST_PUSH_SR,
        ST_VEC_RD,
        ST_VEC_LD,
        ST_RET_SR,
        ST_RET_PC,
        ST_RET_FIN
    } seq_state_e;

endpackage

// File: rtl/irq_seq_gate.sv
// Decides, at an instruction boundary, whether a return or an entry starts.
// Assumes the caller passes idle=1 only when no sequence is running.
// A return has priority over a request at the same boundary.
module irq_seq_gate (
    input  logic idle,
    input  logic insn_done,
    input  logic reti_strobe,
    input  logic irq_req,
    input  logic gie,
    output logic start_entry,
    output logic start_return
);

    logic boundary;

    // boundary qualification and priority between return and entry
    always_comb begin
        boundary     = idle && insn_done;
        start_return = boundary && reti_strobe;
        start_entry  = boundary && !reti_strobe && irq_req && gie;
    end

endmodule

// File: rtl/irq_seq_vecaddr.sv
// Turns a vector slot number into the byte address of its table entry.
// Assumes one word per slot; higher slots sit at higher addresses.
module irq_seq_vecaddr #(
    parameter int unsigned AW       = 16,
    parameter int unsigned IDX_W    = 5,
    parameter int unsigned VEC_BASE = 'hFF80,
    parameter int unsigned SLOT_B   = 2
) (
    input  logic [IDX_W-1:0] slot,
    output logic [AW-1:0]    addr
);

    localparam logic [AW-1:0] BASE_A = AW'(VEC_BASE);
    localparam logic [AW-1:0] STEP_A = AW'(SLOT_B);

    // base plus slot times word size
    always_comb addr = BASE_A + (AW'(slot) * STEP_A);

endmodule

// File: rtl/irq_entry_seq.sv
// Interrupt entry and return sequencer.
// On entry it pushes the PC and then the status word, clears the status
// (GIE included), releases a dedicated flag, and loads the PC from the
// vector table. On return it pops the status word and then the PC.
// Assumes a synchronous memory whose read data arrives one cycle after
// the request, and AW == DW.
module irq_entry_seq
    import irq_seq_pkg::*;
#(
    parameter int unsigned AW       = 16,
    parameter int unsigned DW       = 16,
    parameter int unsigned IDX_W    = 5,
    parameter int unsigned VEC_BASE = 'hFF80,
    parameter int unsigned GIE_BIT  = 3,
    parameter int unsigned SR_KEEP  = 'h00F0,
    parameter int unsigned PC_RST   = 'h4400,
    parameter int unsigned SP_RST   = 'h2400,
    parameter int unsigned SR_RST   = 'h0000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             insn_done,
    input  logic             reti_strobe,
    input  logic             irq_req,
    input  logic [IDX_W-1:0] irq_idx,
    input  logic             irq_grouped,
    input  logic [AW-1:0]    ret_addr,
    input  logic             sr_wr_en,
    input  logic [DW-1:0]    sr_wr_data,
    output logic             mem_req,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [DW-1:0]    mem_wdata,
    input  logic [DW-1:0]    mem_rdata,
    output logic             flag_clr,
    output logic [IDX_W-1:0] flag_clr_idx,
    output logic             busy,
    output logic [AW-1:0]    pc_q,
    output logic [AW-1:0]    sp_q,
    output logic [DW-1:0]    sr_q
);

    localparam logic [AW-1:0] WSTEP  = AW'(WORD_BYTES);
    localparam logic [DW-1:0] KEEP_M = DW'(SR_KEEP) & ~(DW'(1) << GIE_BIT);

    seq_state_e       state_q;
    logic [AW-1:0]    ret_q;
    logic [IDX_W-1:0] idx_q;
    logic             grp_q;
    logic             start_entry;
    logic             start_return;
    logic [AW-1:0]    vec_addr;

    irq_seq_gate gate_i (
        .idle         (state_q == ST_IDLE),
        .insn_done    (insn_done),
        .reti_strobe  (reti_strobe),
        .irq_req      (irq_req),
        .gie          (sr_q[GIE_BIT]),
        .start_entry  (start_entry),
        .start_return (start_return)
    );

    irq_seq_vecaddr #(
        .AW       (AW),
        .IDX_W    (IDX_W),
        .VEC_BASE (VEC_BASE),
        .SLOT_B   (WORD_BYTES)
    ) vec_i (
        .slot (idx_q),
        .addr (vec_addr)
    );

    // sequence state and the architectural registers it owns
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pc_q    <= AW'(PC_RST);
            sp_q    <= AW'(SP_RST);
            sr_q    <= DW'(SR_RST);
            ret_q   <= '0;
            idx_q   <= '0;
            grp_q   <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start_return) begin
                        state_q <= ST_RET_SR;
                    end else if (start_entry) begin
                        state_q <= ST_PUSH_PC;
                        ret_q   <= ret_addr;
                        idx_q   <= irq_idx;
                        grp_q   <= irq_grouped;
                    end else if (sr_wr_en) begin
                        sr_q <= sr_wr_data;
                    end
                end
                ST_PUSH_PC: begin
                    sp_q    <= sp_q - WSTEP;
                    state_q <= ST_PUSH_SR;
                end
                ST_PUSH_SR: begin
                    sp_q    <= sp_q - WSTEP;
                    sr_q    <= sr_q & KEEP_M;
                    state_q <= ST_VEC_RD;
                end
                ST_VEC_RD: state_q <= ST_VEC_LD;
                ST_VEC_LD: begin
                    pc_q    <= AW'(mem_rdata);
                    state_q <= ST_IDLE;
                end
                ST_RET_SR: begin
                    sp_q    <= sp_q + WSTEP;
                    state_q <= ST_RET_PC;
                end
                ST_RET_PC: begin
                    sr_q    <= mem_rdata;
                    sp_q    <= sp_q + WSTEP;
                    state_q <= ST_RET_FIN;
                end
                ST_RET_FIN: begin
                    pc_q    <= AW'(mem_rdata);
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // memory port, flag release and busy, all decoded from state
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        case (state_q)
            ST_PUSH_PC: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = sp_q - WSTEP;
                mem_wdata = DW'(ret_q);
            end
            ST_PUSH_SR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = sp_q - WSTEP;
                mem_wdata = sr_q;
            end
            ST_VEC_RD: begin
                mem_req  = 1'b1;
                mem_addr = vec_addr;
            end
            ST_RET_SR, ST_RET_PC: begin
                mem_req  = 1'b1;
                mem_addr = sp_q;
            end
            default: ;
        endcase
        flag_clr     = (state_q == ST_VEC_RD) && !grp_q;
        flag_clr_idx = idx_q;
        busy         = (state_q != ST_IDLE);
    end

endmodule

// File: rtl/irq_entry_seq_chk.sv
// Protocol checker for irq_entry_seq, attached by bind.
// Observes ports only; assumes the default word size of 2 bytes.
module irq_entry_seq_chk #(
    parameter int unsigned AW       = 16,
    parameter int unsigned DW       = 16,
    parameter int unsigned VEC_BASE = 'hFF80,
    parameter int unsigned GIE_BIT  = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          insn_done,
    input logic          mem_req,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic          flag_clr,
    input logic          busy,
    input logic [AW-1:0] sp_q,
    input logic [DW-1:0] sr_q
);

    // a sequence begins only at an instruction boundary
    assert_start_at_boundary_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(insn_done));

    // an entry begins only while global enable was set
    assert_entry_needs_gie_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy) && mem_we) |-> $past(sr_q[GIE_BIT]));

    // the second push lands one word below the first
    assert_push_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && $past(mem_req && mem_we)) |-> (mem_addr == $past(mem_addr) - AW'(2)));

    // each push moves the stack pointer onto the written slot
    assert_sp_follows_push_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |=> (sp_q == $past(mem_addr)));

    // GIE is already clear when the vector is read
    assert_gie_clear_at_vector_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && $past(mem_we)) |-> !sr_q[GIE_BIT]);

    // the vector read after the pushes targets the table
    assert_vector_in_table_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && $past(mem_we)) |-> (mem_addr >= AW'(VEC_BASE)));

    // a flag clear only occurs as the vector is read
    assert_flag_clr_in_seq_R5: assert property (@(posedge clk) disable iff (!rst_n)
        flag_clr |-> (busy && mem_req && !mem_we));

endmodule

bind irq_entry_seq irq_entry_seq_chk #(
    .AW       (AW),
    .DW       (DW),
    .VEC_BASE (VEC_BASE),
    .GIE_BIT  (GIE_BIT)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .insn_done (insn_done),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .flag_clr  (flag_clr),
    .busy      (busy),
    .sp_q      (sp_q),
    .sr_q      (sr_q)
);

// File: tb/irq_entry_seq_tb_top.sv
// Scoreboard bench: tasks queue expected memory accesses, a monitor
// compares them with the port as the design issues them.
module irq_entry_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        insn_done = 1'b0;
    logic        reti_strobe = 1'b0;
    logic        irq_req = 1'b0;
    logic [4:0]  irq_idx = '0;
    logic        irq_grouped = 1'b0;
    logic [15:0] ret_addr = '0;
    logic        sr_wr_en = 1'b0;
    logic [15:0] sr_wr_data = '0;
    logic        mem_req, mem_we, flag_clr, busy;
    logic [15:0] mem_addr, mem_wdata, pc_q, sp_q, sr_q;
    logic [15:0] mem_rdata = '0;
    logic [4:0]  flag_clr_idx;

    int checks = 0;
    int errors = 0;
    int clr_cnt = 0;
    logic [4:0] clr_last = '0;

    typedef struct packed {
        logic        we;
        logic [15:0] addr;
        logic [15:0] data;
    } op_t;
    op_t exp_q[$];
    logic [15:0] mem_m [logic [15:0]];

    always #4 clk = ~clk;

    irq_entry_seq dut_i (
        .clk(clk), .rst_n(rst_n), .insn_done(insn_done), .reti_strobe(reti_strobe),
        .irq_req(irq_req), .irq_idx(irq_idx), .irq_grouped(irq_grouped),
        .ret_addr(ret_addr), .sr_wr_en(sr_wr_en), .sr_wr_data(sr_wr_data),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .flag_clr(flag_clr), .flag_clr_idx(flag_clr_idx),
        .busy(busy), .pc_q(pc_q), .sp_q(sp_q), .sr_q(sr_q)
    );

    // synchronous memory model: write at the edge, read data one cycle later
    always @(posedge clk) begin
        if (mem_req && mem_we) mem_m[mem_addr] = mem_wdata;
        if (mem_req && !mem_we)
            mem_rdata <= mem_m.exists(mem_addr) ? mem_m[mem_addr] : 16'h0000;
    end

    task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic expect_op(input logic we, input logic [15:0] addr, input logic [15:0] data);
        op_t o;
        o.we = we; o.addr = addr; o.data = data;
        exp_q.push_back(o);
    endtask

    // monitor: compare every access with the head of the queue
    always @(negedge clk) begin
        if (rst_n && mem_req) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R3/R8/R12 unexpected access", mem_addr, 16'h0000);
            end else begin
                op_t o;
                o = exp_q.pop_front();
                chk(mem_we == o.we, "R3/R8 access direction", {15'd0, mem_we}, {15'd0, o.we});
                chk(mem_addr == o.addr, "R3/R6/R8 access address", mem_addr, o.addr);
                if (o.we) chk(mem_wdata == o.data, "R3 pushed value", mem_wdata, o.data);
            end
        end
        if (rst_n && flag_clr) begin
            clr_cnt++;
            clr_last = flag_clr_idx;
        end
    end

    // run an entry from the boundary and check its timing and results
    task automatic do_entry(input logic [4:0] idx, input logic grp, input logic [15:0] ra,
                            input logic [15:0] sr_old, input logic [15:0] hnd, input bit poke_sr);
        logic [15:0] sp0;
        int clr0;
        sp0  = sp_q;
        clr0 = clr_cnt;
        expect_op(1'b1, sp0 - 16'd2, ra);
        expect_op(1'b1, sp0 - 16'd4, sr_old);
        expect_op(1'b0, 16'hFF80 + {10'd0, idx, 1'b0}, 16'h0000);
        insn_done = 1'b1; irq_req = 1'b1; irq_idx = idx; irq_grouped = grp; ret_addr = ra;
        @(negedge clk);
        insn_done = 1'b0; irq_req = 1'b0;
        for (int k = 0; k < 4; k++) begin
            chk(busy == 1'b1, "R7 busy during entry", {15'd0, busy}, 16'd1);
            if (k == 0 && poke_sr) begin sr_wr_en = 1'b1; sr_wr_data = 16'hFFFF; end
            @(negedge clk);
            sr_wr_en = 1'b0;
        end
        chk(busy == 1'b0, "R7 busy falls after entry", {15'd0, busy}, 16'd0);
        chk(pc_q == hnd, "R6 handler loaded", pc_q, hnd);
        chk(sp_q == sp0 - 16'd4, "R3 stack pointer after entry", sp_q, sp0 - 16'd4);
        chk(sr_q == (sr_old & 16'h00F0), "R4 status cleared", sr_q, sr_old & 16'h00F0);
        if (!grp) begin
            chk(clr_cnt == clr0 + 1, "R5 dedicated flag cleared once", 16'(clr_cnt - clr0), 16'd1);
            chk(clr_last == idx, "R5 cleared slot", {11'd0, clr_last}, {11'd0, idx});
        end else begin
            chk(clr_cnt == clr0, "R5 grouped flag left set", 16'(clr_cnt - clr0), 16'd0);
        end
    endtask

    // run a return; optional extra boundary mid-sequence and request alongside
    task automatic do_return(input logic [15:0] exp_sr, input logic [15:0] exp_pc,
                             input bit with_irq, input bit extra_done);
        logic [15:0] sp0;
        sp0 = sp_q;
        expect_op(1'b0, sp0, 16'h0000);
        expect_op(1'b0, sp0 + 16'd2, 16'h0000);
        insn_done = 1'b1; reti_strobe = 1'b1; irq_req = with_irq; irq_idx = 5'd1; irq_grouped = 1'b0;
        @(negedge clk);
        insn_done = 1'b0; reti_strobe = 1'b0; irq_req = 1'b0;
        for (int k = 0; k < 3; k++) begin
            chk(busy == 1'b1, "R7 busy during return", {15'd0, busy}, 16'd1);
            if (k == 1 && extra_done) begin insn_done = 1'b1; reti_strobe = 1'b1; irq_req = 1'b1; end
            @(negedge clk);
            insn_done = 1'b0; reti_strobe = 1'b0; irq_req = 1'b0;
        end
        chk(busy == 1'b0, "R7 busy falls after return", {15'd0, busy}, 16'd0);
        chk(sr_q == exp_sr, "R8 status restored", sr_q, exp_sr);
        chk(pc_q == exp_pc, "R8 PC restored", pc_q, exp_pc);
        chk(sp_q == sp0 + 16'd4, "R8/R12 stack pointer after return", sp_q, sp0 + 16'd4);
    endtask

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        mem_m[16'hFF8A] = 16'h5000;
        mem_m[16'hFF84] = 16'h6000;
        mem_m[16'h2400] = 16'h0001;
        mem_m[16'h2402] = 16'h4500;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(pc_q == 16'h4400, "R1 reset PC", pc_q, 16'h4400);
        chk(sp_q == 16'h2400, "R1 reset SP", sp_q, 16'h2400);
        chk(sr_q == 16'h0000, "R1 reset status", sr_q, 16'h0000);
        chk(!busy && !mem_req, "R1 idle after reset", {14'd0, busy, mem_req}, 16'd0);

        // R2 request with GIE clear is ignored
        insn_done = 1'b1; irq_req = 1'b1; irq_idx = 5'd5;
        @(negedge clk);
        insn_done = 1'b0; irq_req = 1'b0;
        chk(busy == 1'b0, "R2 masked request ignored", {15'd0, busy}, 16'd0);
        chk(sp_q == 16'h2400, "R2 SP untouched", sp_q, 16'h2400);

        // R10 software status write while idle
        sr_wr_en = 1'b1; sr_wr_data = 16'h00F8;
        @(negedge clk);
        sr_wr_en = 1'b0;
        chk(sr_q == 16'h00F8, "R10 status write while idle", sr_q, 16'h00F8);

        // R2 request without a boundary is ignored
        irq_req = 1'b1;
        repeat (2) @(negedge clk);
        irq_req = 1'b0;
        chk(busy == 1'b0, "R2 no boundary, no entry", {15'd0, busy}, 16'd0);

        // R3-R7, R10: dedicated entry with a status write attempted while busy
        do_entry(5'd5, 1'b0, 16'h4410, 16'h00F8, 16'h5000, 1'b1);

        // R9 GIE now clear: a further request does not nest
        insn_done = 1'b1; irq_req = 1'b1; irq_idx = 5'd2;
        @(negedge clk);
        insn_done = 1'b0; irq_req = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0, "R9 no nesting with GIE clear", {15'd0, busy}, 16'd0);
        chk(pc_q == 16'h5000, "R9 PC unchanged", pc_q, 16'h5000);

        // R9 software re-enables GIE, grouped nested entry (R5 no clear)
        sr_wr_en = 1'b1; sr_wr_data = 16'h00F8;
        @(negedge clk);
        sr_wr_en = 1'b0;
        do_entry(5'd2, 1'b1, 16'h5008, 16'h00F8, 16'h6000, 1'b0);

        // R8 unwind both levels, R12 extra boundary during the first
        do_return(16'h00F8, 16'h5008, 1'b0, 1'b1);
        do_return(16'h00F8, 16'h4410, 1'b0, 1'b0);

        // R11 return and request at the same boundary
        do_return(16'h0001, 16'h4500, 1'b1, 1'b0);
        chk(exp_q.size() == 0, "R11 no entry accesses issued", 16'(exp_q.size()), 16'd0);

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0 && !busy, "R11/R12 idle at end", 16'(exp_q.size()), 16'd0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule